// File: doc/BRIEF.md
# PLL power-up bring-up sequencer

This block is a hardware state machine that takes a PLL from power-down into locked operation without software stepping through each control bit. A single start request launches an ordered series of steps. Each step changes one PLL control line, and timed waits counted in reference-clock cycles separate them. The PLL stays in bypass from the start of the run until it has been taken out of power-down, enabled, given time to stabilize, loaded with its multiplier, released from reset and given time to lock. Bypass is released only as the very last step, so the system clocks never see an unsettled PLL output.

The clock-mode selection, multiplier, divider-update flag and the three wait counts (stabilization, reset, lock) are captured when the start request is accepted. If the divider-update flag was set, the sequencer stops after loading the multiplier. It then raises a request to an external post-divider block and waits for that block's acknowledge before it continues. All control outputs are registered. An output changes on the clock edge that ends the step that owns it.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset the outputs are:
  - `clk_mode_o`=0, `byp_own_o`=0, `bypass_o`=1, `pll_rst_o`=0, `pll_dis_o`=0, `pll_pd_o`=1;
  - `mult_o`=0, `mult_ld_o`=0, `div_req_o`=0, `busy_o`=0, `done_o`=0.
- R2: A start request sampled high while idle captures the clock mode, multiplier, divider flag and the three counts. A start request while busy is ignored. Input changes after capture have no effect on the running sequence.
- R3: Counting the start-sampling edge as edge 0, `clk_mode_o` takes the captured mode at edge 1. `byp_own_o` (1 = the bypass-enable output governs bypass) goes to 1 at edge 2. `bypass_o` (1 = bypass) goes to 1 at edge 3.
- R4: After bypass is selected there is a settle wait of 4 cycles. `pll_rst_o` (1 = PLL held in reset) then rises at edge 8.
- R5: `pll_dis_o` (1 = output disabled) rises at edge 9. `pll_pd_o` (1 = powered down) falls at edge 10. `pll_dis_o` falls at edge 11.
- R6: `bypass_o` is 1 whenever `pll_rst_o`, `pll_pd_o` or `pll_dis_o` is 1.
- R7: With S' = max(stabilization count, 1), the captured multiplier appears on `mult_o` at edge Tm = 12+S'. `mult_ld_o` is high for exactly the cycle after edge Tm. `mult_o` changes at no other time.
- R8: With the divider flag set, `div_req_o` rises at edge Tm and holds until `div_ack_i` is sampled high; it falls on that edge (Ta). With the flag clear there is no request, `div_ack_i` is ignored, and Ta = Tm.
- R9: With R' = max(reset count, 1), `pll_rst_o` falls at edge Trel = Ta+R'+1.
- R10: With L' = max(lock count, 1), `bypass_o` falls at edge Tfin = Trel+L'+1. At that edge `done_o` goes high for one cycle. The PLL (lock delay model) is locked by then when the lock count covers its lock time.
- R11: A count of 0 behaves exactly as a count of 1.
- R12: `busy_o` is 1 from edge 0 until edge Tfin, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| clk_mode_i | input | 1 | Requested clock mode |
| mult_i | input | MULT_W | Requested multiplier |
| div_upd_i | input | 1 | Call the divider block during the run |
| stab_cnt_i | input | CNT_W | Stabilization wait, cycles |
| rst_cnt_i | input | CNT_W | Reset wait, cycles |
| lock_cnt_i | input | CNT_W | Lock wait, cycles |
| div_ack_i | input | 1 | Divider block acknowledge |
| clk_mode_o | output | 1 | Clock mode to the PLL |
| byp_own_o | output | 1 | Bypass governed by the bypass-enable output |
| bypass_o | output | 1 | Bypass select |
| pll_rst_o | output | 1 | PLL reset, 1 = in reset |
| pll_dis_o | output | 1 | PLL output disable |
| pll_pd_o | output | 1 | PLL power-down |
| mult_o | output | MULT_W | Multiplier to the PLL |
| mult_ld_o | output | 1 | Multiplier load strobe |
| div_req_o | output | 1 | Divider update request |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each step drives its own registered output, so a state machine that skips, repeats or reorders a step shows as an output edge at the wrong clock edge. That edge appears within one cycle of the step in question. A miscounting wait timer shifts every later edge by the same miscount, so it is seen at the next control change after the wait, at the latest one cycle after the expected edge. Corrupted captured settings show as a wrong value on `mult_o` or `clk_mode_o`, as a missing or spurious divider request, or as wait lengths that differ from the programmed counts.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_MODE, ST_OWN, ST_BYP, ST_WBYP, ST_RST, ST_DIS, ST_PWR,
    ST_EN, ST_WSTAB, ST_MULT, ST_DIV, ST_WRST, ST_REL, ST_WLOCK, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  // zero load is promoted to a one-cycle wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= (val_i == '0) ? CNT_W'(1) : val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int MULT_W   = 5,
  parameter int CNT_W    = 16,
  parameter int BYP_WAIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clk_mode_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              div_upd_i,
  input  logic [CNT_W-1:0]  stab_cnt_i,
  input  logic [CNT_W-1:0]  rst_cnt_i,
  input  logic [CNT_W-1:0]  lock_cnt_i,
  input  logic              div_ack_i,
  input  logic              tmr_last_i,
  output logic              tmr_ld_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              clk_mode_o,
  output logic              byp_own_o,
  output logic              bypass_o,
  output logic              pll_rst_o,
  output logic              pll_dis_o,
  output logic              pll_pd_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              mult_ld_o,
  output logic              div_req_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] BypCnt = CNT_W'(BYP_WAIT);

  seq_state_e st_q, st_d;
  logic              mode_q, div_q;
  logic [MULT_W-1:0] mult_q;
  logic [CNT_W-1:0]  stab_q, rcnt_q, lock_q;

  always_comb begin
    st_d      = st_q;
    tmr_ld_o  = 1'b0;
    tmr_val_o = '0;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_MODE;
      ST_MODE:  st_d = ST_OWN;
      ST_OWN:   st_d = ST_BYP;
      ST_BYP:   begin st_d = ST_WBYP; tmr_ld_o = 1'b1; tmr_val_o = BypCnt; end
      ST_WBYP:  if (tmr_last_i) st_d = ST_RST;
      ST_RST:   st_d = ST_DIS;
      ST_DIS:   st_d = ST_PWR;
      ST_PWR:   st_d = ST_EN;
      ST_EN:    begin st_d = ST_WSTAB; tmr_ld_o = 1'b1; tmr_val_o = stab_q; end
      ST_WSTAB: if (tmr_last_i) st_d = ST_MULT;
      ST_MULT: begin
        if (div_q) st_d = ST_DIV;
        else begin st_d = ST_WRST; tmr_ld_o = 1'b1; tmr_val_o = rcnt_q; end
      end
      ST_DIV:   if (div_ack_i) begin st_d = ST_WRST; tmr_ld_o = 1'b1; tmr_val_o = rcnt_q; end
      ST_WRST:  if (tmr_last_i) st_d = ST_REL;
      ST_REL:   begin st_d = ST_WLOCK; tmr_ld_o = 1'b1; tmr_val_o = lock_q; end
      ST_WLOCK: if (tmr_last_i) st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      {mode_q, div_q} <= '0;
      mult_q <= '0;
      {stab_q, rcnt_q, lock_q} <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) begin
        mode_q <= clk_mode_i;
        div_q  <= div_upd_i;
        mult_q <= mult_i;
        stab_q <= stab_cnt_i;
        rcnt_q <= rst_cnt_i;
        lock_q <= lock_cnt_i;
      end
    end
  end

  // each output changes on the edge that ends its owning step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_mode_o <= 1'b0;
      byp_own_o  <= 1'b0;
      bypass_o   <= 1'b1;
      pll_rst_o  <= 1'b0;
      pll_dis_o  <= 1'b0;
      pll_pd_o   <= 1'b1;
      mult_o     <= '0;
      mult_ld_o  <= 1'b0;
      div_req_o  <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      mult_ld_o <= (st_q == ST_MULT);
      done_o    <= (st_q == ST_FIN);
      unique case (st_q)
        ST_MODE: clk_mode_o <= mode_q;
        ST_OWN:  byp_own_o  <= 1'b1;
        ST_BYP:  bypass_o   <= 1'b1;
        ST_RST:  pll_rst_o  <= 1'b1;
        ST_DIS:  pll_dis_o  <= 1'b1;
        ST_PWR:  pll_pd_o   <= 1'b0;
        ST_EN:   pll_dis_o  <= 1'b0;
        ST_MULT: begin mult_o <= mult_q; div_req_o <= div_q; end
        ST_DIV:  if (div_ack_i) div_req_o <= 1'b0;
        ST_REL:  pll_rst_o  <= 1'b0;
        ST_FIN:  bypass_o   <= 1'b0;
        default: ;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq #(
  parameter int MULT_W   = 5,
  parameter int CNT_W    = 16,
  parameter int BYP_WAIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clk_mode_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              div_upd_i,
  input  logic [CNT_W-1:0]  stab_cnt_i,
  input  logic [CNT_W-1:0]  rst_cnt_i,
  input  logic [CNT_W-1:0]  lock_cnt_i,
  input  logic              div_ack_i,
  output logic              clk_mode_o,
  output logic              byp_own_o,
  output logic              bypass_o,
  output logic              pll_rst_o,
  output logic              pll_dis_o,
  output logic              pll_pd_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              mult_ld_o,
  output logic              div_req_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             tmr_ld, tmr_last;
  logic [CNT_W-1:0] tmr_val;

  pll_seq_ctrl #(.MULT_W(MULT_W), .CNT_W(CNT_W), .BYP_WAIT(BYP_WAIT)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .clk_mode_i, .mult_i, .div_upd_i,
    .stab_cnt_i, .rst_cnt_i, .lock_cnt_i, .div_ack_i,
    .tmr_last_i(tmr_last), .tmr_ld_o(tmr_ld), .tmr_val_o(tmr_val),
    .clk_mode_o, .byp_own_o, .bypass_o, .pll_rst_o, .pll_dis_o, .pll_pd_o,
    .mult_o, .mult_ld_o, .div_req_o, .busy_o, .done_o
  );

  pll_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_ld), .val_i(tmr_val), .last_o(tmr_last)
  );
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk #(
  parameter int MULT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              div_ack_i,
  input logic              byp_own_o,
  input logic              bypass_o,
  input logic              pll_rst_o,
  input logic              pll_dis_o,
  input logic              pll_pd_o,
  input logic [MULT_W-1:0] mult_o,
  input logic              mult_ld_o,
  input logic              div_req_o,
  input logic              busy_o,
  input logic              done_o
);
  // R6
  byp_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_o |-> !pll_rst_o && !pll_pd_o && !pll_dis_o);
  // R4
  rst_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_rst_o) |-> bypass_o && byp_own_o);
  // R5
  pd_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_pd_o) |-> pll_rst_o && pll_dis_o);
  // R5
  dis_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_dis_o) |-> !pll_pd_o && pll_rst_o);
  // R7
  mult_ld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_ld_o |-> pll_rst_o && bypass_o && !pll_pd_o);
  // R7
  mult_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mult_ld_o |-> $stable(mult_o));
  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_req_o && !div_ack_i |=> div_req_o);
  // R10
  byp_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bypass_o) |-> done_o && !busy_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R12
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(.MULT_W(MULT_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .div_ack_i, .byp_own_o, .bypass_o, .pll_rst_o,
  .pll_dis_o, .pll_pd_o, .mult_o, .mult_ld_o, .div_req_o, .busy_o, .done_o
);

// File: tb/pll_bringup_seq_test.sv
`timescale 1ns/1ps
module pll_bringup_seq_test;
  localparam int MW = 5, CW = 16, LOCK_T = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, clk_mode_i = 0, div_upd_i = 0, div_ack_i = 0;
  logic [MW-1:0] mult_i = '0;
  logic [CW-1:0] stab_cnt_i = '0, rst_cnt_i = '0, lock_cnt_i = '0;
  logic clk_mode_o, byp_own_o, bypass_o, pll_rst_o, pll_dis_o, pll_pd_o;
  logic [MW-1:0] mult_o;
  logic mult_ld_o, div_req_o, busy_o, done_o;

  always #5 clk = ~clk;

  pll_bringup_seq #(.MULT_W(MW), .CNT_W(CW)) uut (.clk_i(clk), .*);

  int checks = 0, fails = 0, last_done = -1;
  // bench copy of settled outputs between runs
  int p_mode = 0, p_own = 0, p_byp = 1, p_rst = 0, p_dis = 0, p_pd = 1, p_mult = 0;

  // PLL lock delay model
  int lk_cnt = 0;
  always @(posedge clk)
    if (pll_rst_o || pll_pd_o || pll_dis_o) lk_cnt <= 0;
    else if (lk_cnt < 1000) lk_cnt <= lk_cnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mx1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_seq(input int m, input int mv, input int dv, input int s,
                         input int r, input int l, input int d, input bit intr);
    int tm, ta, trel, tfin;
    tm = 12 + mx1(s);
    ta = dv ? tm + d + 1 : tm;
    trel = ta + mx1(r) + 1;
    tfin = trel + mx1(l) + 1;
    last_done = -1;
    @(negedge clk);
    clk_mode_i = m[0]; mult_i = MW'(mv); div_upd_i = dv[0];
    stab_cnt_i = CW'(s); rst_cnt_i = CW'(r); lock_cnt_i = CW'(l);
    start_i = 1;
    for (int k = 0; k <= tfin + 1; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 0) start_i = 0;
      chk("R3 mode", clk_mode_o, k >= 1 ? m : p_mode);
      chk("R3 own", byp_own_o, k >= 2 ? 1 : p_own);
      chk(k < tfin - 1 ? "R6 bypass" : "R10 bypass", bypass_o,
          k >= tfin ? 0 : (k >= 3 ? 1 : p_byp));
      chk(k < tm ? "R4 pll_rst" : "R9 pll_rst", pll_rst_o,
          (k >= 8 && k < trel) ? 1 : (k >= trel ? 0 : p_rst));
      chk("R5 dis", pll_dis_o, (k >= 9 && k < 11) ? 1 : (k >= 11 ? 0 : p_dis));
      chk("R5 pd", pll_pd_o, k >= 10 ? 0 : p_pd);
      chk("R7 mult", mult_o, k >= tm ? mv : p_mult);
      chk("R7 ld", mult_ld_o, k == tm ? 1 : 0);
      chk("R8 req", div_req_o, (dv != 0 && k >= tm && k < ta) ? 1 : 0);
      chk("R12 busy", busy_o, k < tfin ? 1 : 0);
      chk("R10 done", done_o, k == tfin ? 1 : 0);
      if (k == tfin && l >= LOCK_T) chk("R10 locked", lk_cnt >= LOCK_T ? 1 : 0, 1);
      if (done_o) last_done = k;
      div_ack_i = (k == tm + d);
      // R2: scramble inputs after capture
      clk_mode_i = 1'($urandom); mult_i = MW'($urandom); div_upd_i = 1'($urandom);
      stab_cnt_i = CW'($urandom); rst_cnt_i = CW'($urandom); lock_cnt_i = CW'($urandom);
      if (intr && k == 5) start_i = 1;
      if (intr && k == 6) start_i = 0;
    end
    div_ack_i = 0;
    p_mode = m; p_own = 1; p_byp = 0; p_rst = 0; p_dis = 0; p_pd = 0; p_mult = mv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #23;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", clk_mode_o, 0); chk("R1 own", byp_own_o, 0);
    chk("R1 bypass", bypass_o, 1); chk("R1 rst", pll_rst_o, 0);
    chk("R1 dis", pll_dis_o, 0); chk("R1 pd", pll_pd_o, 1);
    chk("R1 mult", mult_o, 0); chk("R1 ld", mult_ld_o, 0);
    chk("R1 req", div_req_o, 0); chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle busy", busy_o, 0);

    // directed: no divider call, plain counts
    run_seq(1, 13, 0, 3, 2, 7, 0, 0);
    // directed R11: all counts zero, compare against counts of one
    run_seq(0, 5, 0, 0, 0, 0, 0, 0);
    chk("R11 done edge zero counts", last_done, 12 + 1 + 1 + 1 + 1 + 1);
    run_seq(1, 6, 0, 1, 1, 1, 0, 0);
    chk("R11 done edge unit counts", last_done, 17);
    // R8: divider handshake with immediate and delayed acknowledge
    run_seq(0, 31, 1, 4, 3, 8, 0, 0);
    run_seq(1, 9, 1, 2, 5, 6, 7, 0);
    // R2: start while busy with changed settings
    run_seq(0, 20, 0, 5, 4, 9, 0, 1);
    chk("R2 mult kept", mult_o, 20);
    // random runs
    for (int i = 0; i < 24; i++)
      run_seq(int'($urandom_range(1)), int'($urandom_range(31)), int'($urandom_range(1)),
              int'($urandom_range(20)), int'($urandom_range(20)),
              int'($urandom_range(20, LOCK_T)), int'($urandom_range(6)),
              bit'($urandom_range(1)));
    repeat (3) @(negedge clk);
    chk("R12 idle after runs", busy_o, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule